// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a level-one data cache placed between the memory stage of a pipelined processor and a slow main memory. The processor presents a read or write strobe with a 32-bit word address and, for stores, a data word. A hit is answered in the same cycle. A miss raises a stall output that freezes the pipeline while the cache moves whole four-word lines to and from memory.

The cache holds 8,192 words in 2,048 lines of four words: 1,024 sets, each with two ways. Every line keeps a tag, a valid flag and a dirty flag, and every set keeps a recency bit that names its least recently used way. Stores write only the cached copy. A modified line returns to memory only when it is evicted, and that write-back always comes before the refill of the replacing line. Store misses allocate: the line is fetched first and the word is merged afterwards.

The memory side runs one 128-bit line transfer at a time. The cache holds a request until memory acknowledges it. The processor keeps its request steady while stalled, and the cache works from the copy it latched when the miss was found.

Top module: `wb_cache2w`

## Requirements
- R1: After reset every line is invalid. `cpu_stall` and `mem_req` are low, and the first access to any address misses.
- R2: The word address is split into three fields. Bits [31:12] are the tag, bits [11:2] select one of 1,024 sets, and bits [1:0] select the word within the line.
- R3: An access to a valid line with a matching tag in either way is a hit. On a hit `cpu_stall` stays low in that cycle, and a read returns the addressed word on `cpu_rdata` in that same cycle.
- R4: A store hit changes only the cached word and marks the line dirty. It causes no memory request.
- R5: On a miss, `cpu_stall` is high from the cycle the miss is seen until the cycle the access completes. A clean miss issues a single line read whose address is the request's tag and set with word bits 00, so the stall lasts one cycle plus the memory latency.
- R6: If the victim line is dirty, the whole victim line is first written to the address formed from its own tag and set. The refill read follows, so the stall lasts one cycle plus two memory latencies.
- R7: The victim is chosen in this order: way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way. Every completed access, including the one that ends a miss, makes the accessed way the most recent in its set.
- R8: A store miss fetches the line, then merges the store word into it and marks the line dirty, so a later eviction of that line writes it back.
- R9: While `cpu_stall` is high, changes on `cpu_addr`, `cpu_wdata`, `cpu_rd` and `cpu_wr` have no effect. The miss completes for the request latched when it began.
- R10: `mem_req`, `mem_we` and `mem_addr` stay constant until `mem_ack` pulses. `mem_we` is 1 for a write-back and 0 for a refill. Word k of a line occupies bits [32k+31:32k] of `mem_wline` and `mem_rline`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_rd | input | 1 | Processor load strobe |
| cpu_wr | input | 1 | Processor store strobe (wins over `cpu_rd`) |
| cpu_addr | input | 32 | Word address: tag, set, word |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the read completes |
| cpu_stall | output | 1 | Holds the pipeline during a miss |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 for a write-back, 0 for a refill |
| mem_addr | output | 32 | Line word address, low two bits zero |
| mem_wline | output | 128 | Line written back to memory |
| mem_rline | input | 128 | Line returned by memory, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion pulse from memory |

## Verification
Two functions can share a single miss: the write-back of a dirty least recently used victim and the refill of the requested line. The bench provokes this in two ways. It dirties a line with a store hit, then ages that line by touching the other way of its set. It also dirties a line through a store miss and then evicts it. In each case it judges the stall length (1 + 2×20 cycles), the write-back address and the written-back word as memory received them, and the data returned by the refill. A third case changes the processor inputs in the middle of a miss and confirms the result still belongs to the original request.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    CST_IDLE = 2'd0,
    CST_WBACK = 2'd1,
    CST_FILL = 2'd2,
    CST_RESP = 2'd3
  } cwb_state_e;
endpackage

// File: rtl/cwb_tag_way.sv
module cwb_tag_way #(
  parameter int INDEX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  input  logic [TAG_W-1:0]   cmp_tag,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               dirty_set_en,
  output logic               hit,
  output logic               valid,
  output logic               dirty,
  output logic [TAG_W-1:0]   tag
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [SETS];

  assign valid = valid_q[idx];
  assign dirty = dirty_q[idx];
  assign tag   = tag_q[idx];
  assign hit   = valid && (tag == cmp_tag);

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_en) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = 1'b0;
    end else if (dirty_set_en) begin
      dirty_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_set_en |-> valid) else $error("dirty set on invalid line"); // R4
endmodule

// File: rtl/cwb_data_way.sv
module cwb_data_way #(
  parameter int INDEX_W = 10,
  parameter int DATA_W = 32,
  parameter int WORDS = 4
) (
  input  logic                       clk,
  input  logic [INDEX_W-1:0]         idx,
  input  logic                       fill_en,
  input  logic [DATA_W*WORDS-1:0]    fill_line,
  input  logic                       wr_en,
  input  logic [$clog2(WORDS)-1:0]   wr_off,
  input  logic [DATA_W-1:0]          wr_word,
  output logic [DATA_W*WORDS-1:0]    line
);
  localparam int SETS = 1 << INDEX_W;
  localparam int LINE_W = DATA_W * WORDS;

  logic [LINE_W-1:0] arr_q [SETS];
  logic [LINE_W-1:0] merged;

  assign line = arr_q[idx];

  always_comb begin
    merged = line;
    for (int k = 0; k < WORDS; k++) begin
      if (wr_off == k[$clog2(WORDS)-1:0]) merged[k*DATA_W +: DATA_W] = wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en)     arr_q[idx] <= fill_line;
    else if (wr_en)  arr_q[idx] <= merged;
  end
endmodule

// File: rtl/cwb_lru.sv
module cwb_lru #(
  parameter int INDEX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  input  logic               touch_en,
  input  logic               touch_way,
  output logic               evict_way
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0] old_q, old_d;

  assign evict_way = old_q[idx];

  always_comb begin
    old_d = old_q;
    if (touch_en) old_d[idx] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else        old_q <= old_d;
  end

  AST_LRU_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (idx != $past(idx)) || (evict_way != $past(touch_way)))
    else $error("touched way not most recent"); // R7
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int INDEX_W = 10,
  parameter int OFF_W = 2,
  parameter int TAG_W = ADDR_W - INDEX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              hit_any,
  input  logic [1:0]        way_valid,
  input  logic [1:0]        way_dirty,
  input  logic [TAG_W-1:0]  tag_w0,
  input  logic [TAG_W-1:0]  tag_w1,
  input  logic              lru_way,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              eff_wr,
  output logic [DATA_W-1:0] eff_wdata,
  output logic              access_done,
  output logic              fill_en,
  output logic              vic_way,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  cwb_state_e        state_q, state_d;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic              lat_wr_q;
  logic              vic_way_q;
  logic [TAG_W-1:0]  vic_tag_q;

  logic              idle, req_idle, miss_idle;
  logic              vic_sel, vic_dirty;
  logic [TAG_W-1:0]  vic_tag_sel;

  assign idle      = (state_q == CST_IDLE);
  assign req_idle  = idle && (cpu_rd || cpu_wr);
  assign miss_idle = req_idle && !hit_any;

  assign eff_addr  = idle ? cpu_addr  : lat_addr_q;
  assign eff_wr    = idle ? cpu_wr    : lat_wr_q;
  assign eff_wdata = idle ? cpu_wdata : lat_wdata_q;

  // victim order: invalid way 0, invalid way 1, then least recent
  always_comb begin
    if (!way_valid[0])      vic_sel = 1'b0;
    else if (!way_valid[1]) vic_sel = 1'b1;
    else                    vic_sel = lru_way;
  end
  assign vic_dirty   = way_valid[vic_sel] && way_dirty[vic_sel];
  assign vic_tag_sel = vic_sel ? tag_w1 : tag_w0;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CST_IDLE:  if (miss_idle) state_d = vic_dirty ? CST_WBACK : CST_FILL;
      CST_WBACK: if (mem_ack)   state_d = CST_FILL;
      CST_FILL:  if (mem_ack)   state_d = CST_RESP;
      default:                  state_d = CST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (miss_idle) begin
      lat_addr_q  <= cpu_addr;
      lat_wdata_q <= cpu_wdata;
      lat_wr_q    <= cpu_wr;
      vic_way_q   <= vic_sel;
      vic_tag_q   <= vic_tag_sel;
    end
  end

  assign access_done = (req_idle && hit_any) || (state_q == CST_RESP);
  assign fill_en     = (state_q == CST_FILL) && mem_ack;
  assign vic_way     = vic_way_q;
  assign cpu_stall   = miss_idle || (state_q == CST_WBACK) || (state_q == CST_FILL);
  assign mem_req     = (state_q == CST_WBACK) || (state_q == CST_FILL);
  assign mem_we      = (state_q == CST_WBACK);
  assign mem_addr    = {(mem_we ? vic_tag_q : lat_addr_q[ADDR_W-1 -: TAG_W]),
                        lat_addr_q[OFF_W +: INDEX_W], {OFF_W{1'b0}}};

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)))
    else $error("memory request dropped or changed"); // R10
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we))
    else $error("write-back not followed by refill"); // R6
  AST_RESP_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CST_RESP) |-> hit_any)
    else $error("refilled line not found"); // R8
endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS = 4,
  parameter int INDEX_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_stall,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W*WORDS-1:0] mem_wline,
  input  logic [DATA_W*WORDS-1:0] mem_rline,
  input  logic                    mem_ack
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int NWAYS  = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0]  eff_addr;
  logic               eff_wr;
  logic [DATA_W-1:0]  eff_wdata;
  logic               access_done, fill_en, vic_way, lru_way;
  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   req_tag;
  logic [OFF_W-1:0]   off;
  logic [NWAYS-1:0]   hit_w, valid_w, dirty_w;
  logic [TAG_W-1:0]   tag_w [NWAYS];
  logic [LINE_W-1:0]  line_w [NWAYS];
  logic               hit_any, hit_way;
  logic [LINE_W-1:0]  sel_line;

  assign idx     = eff_addr[OFF_W +: INDEX_W];
  assign req_tag = eff_addr[ADDR_W-1 -: TAG_W];
  assign off     = eff_addr[OFF_W-1:0];
  assign hit_any = |hit_w;
  assign hit_way = hit_w[1];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic way_fill, way_wr;
    assign way_fill = fill_en && (vic_way == w[0]);
    assign way_wr   = access_done && eff_wr && hit_w[w];

    cwb_tag_way #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tag (
      .clk(clk), .rst_n(rst_int_n), .idx(idx), .cmp_tag(req_tag),
      .fill_en(way_fill), .fill_tag(req_tag), .dirty_set_en(way_wr),
      .hit(hit_w[w]), .valid(valid_w[w]), .dirty(dirty_w[w]), .tag(tag_w[w])
    );

    cwb_data_way #(.INDEX_W(INDEX_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_data (
      .clk(clk), .idx(idx), .fill_en(way_fill), .fill_line(mem_rline),
      .wr_en(way_wr), .wr_off(off), .wr_word(eff_wdata), .line(line_w[w])
    );
  end

  cwb_lru #(.INDEX_W(INDEX_W)) u_lru (
    .clk(clk), .rst_n(rst_int_n), .idx(idx), .touch_en(access_done),
    .touch_way(hit_way), .evict_way(lru_way)
  );

  cwb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .hit_any(hit_any),
    .way_valid(valid_w), .way_dirty(dirty_w), .tag_w0(tag_w[0]), .tag_w1(tag_w[1]),
    .lru_way(lru_way), .mem_ack(mem_ack), .eff_addr(eff_addr), .eff_wr(eff_wr),
    .eff_wdata(eff_wdata), .access_done(access_done), .fill_en(fill_en),
    .vic_way(vic_way), .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr)
  );

  assign sel_line  = line_w[hit_way];
  assign cpu_rdata = sel_line[off*DATA_W +: DATA_W];
  assign mem_wline = line_w[vic_way];

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(hit_w)) else $error("tag present in both ways"); // R3
  AST_MEM_STALLS: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> cpu_stall) else $error("memory busy without stall"); // R5
  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && !cpu_stall) |=> !mem_req) else $error("store hit reached memory"); // R4
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0)) else $error("unaligned line address"); // R10
endmodule

// File: tb/wb_cache2w_tb_top.sv
module wb_cache2w_tb_top;
  localparam int LAT = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_stall, mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wline, mem_rline;
  logic         mem_ack;

  int checks = 0, fails = 0;
  int wb_count = 0, rd_count = 0;
  logic [31:0] last_wb_addr = '0, last_rd_addr = '0;

  logic [127:0] mline [int];
  logic [31:0]  gold [int];
  logic [31:0]  exp_q [$];
  string        tag_q [$];
  int           cnt = 0;

  always #10 clk = ~clk;

  wb_cache2w dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
    .mem_ack(mem_ack)
  );

  function automatic logic [31:0] initval(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] la);
    logic [127:0] l;
    if (mline.exists(int'(la))) return mline[int'(la)];
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = initval(la + k);
    return l;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    if (gold.exists(int'(a))) return gold[int'(a)];
    return initval(a);
  endfunction

  function automatic logic [31:0] mk(input int tg, input int ix, input int of);
    return (32'(tg) << 12) | (32'(ix) << 2) | 32'(of);
  endfunction

  // main memory model: LAT cycles per line transfer, ack included
  always_ff @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (cnt == LAT - 2) begin
        cnt     <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mline[int'(mem_addr)] = mem_wline;
          wb_count     <= wb_count + 1;
          last_wb_addr <= mem_addr;
        end else begin
          mem_rline    <= line_of(mem_addr);
          rd_count     <= rd_count + 1;
          last_rd_addr <= mem_addr;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare every completed read
  always @(negedge clk) begin
    if (rst_n && cpu_rd && !cpu_wr && !cpu_stall && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {32'h0, cpu_rdata}, {32'h0, e});
    end
  end

  // driver: one access, returns number of stalled cycles
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input string req, output int stalls);
    @(posedge clk); #1;
    cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    if (wr) gold[int'(a)] = d;
    else begin exp_q.push_back(ref_word(a)); tag_q.push_back(req); end
    stalls = 0;
    @(negedge clk);
    while (cpu_stall && stalls < 1000) begin stalls++; @(negedge clk); end
    @(posedge clk); #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int s, wbs;
    logic [31:0] a_addr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 stall after reset", {63'h0, cpu_stall}, 64'h0);
    check("R1 mem_req after reset", {63'h0, mem_req}, 64'h0);

    a_addr = mk(1, 5, 1);
    access(0, a_addr, 0, "R1 R2 first read data", s);
    check("R5 clean miss stall", 64'(s), 64'(1 + LAT));
    check("R5 refill address", {32'h0, last_rd_addr}, {32'h0, mk(1, 5, 0)});
    access(0, mk(1, 5, 2), 0, "R2 R3 hit word2", s);
    check("R3 hit no stall", 64'(s), 64'h0);
    wbs = rd_count;
    access(1, mk(1, 5, 3), 32'hCAFE_0001, "R4", s);
    check("R4 store hit no stall", 64'(s), 64'h0);
    check("R4 store hit no memory read", 64'(rd_count), 64'(wbs));
    check("R4 store hit no write-back", 64'(wb_count), 64'h0);
    access(0, mk(1, 5, 3), 0, "R4 read back stored word", s);

    access(0, mk(2, 5, 0), 0, "R7 B data", s);
    check("R7 B into invalid way clean miss", 64'(s), 64'(1 + LAT));
    access(0, mk(1, 5, 0), 0, "R7 A retouch", s);
    check("R7 A still resident", 64'(s), 64'h0);
    access(0, mk(3, 5, 2), 0, "R7 C data", s);
    check("R7 C evicts clean LRU B", 64'(s), 64'(1 + LAT));
    check("R7 no write-back for clean B", 64'(wb_count), 64'h0);
    access(0, mk(1, 5, 3), 0, "R7 A survives", s);
    check("R7 A hit after C fill", 64'(s), 64'h0);
    access(0, mk(3, 5, 1), 0, "R7 C touch", s);

    access(0, mk(4, 5, 1), 0, "R6 D data after write-back", s);
    check("R6 dirty miss stall", 64'(s), 64'(1 + 2 * LAT));
    check("R6 one write-back", 64'(wb_count), 64'h1);
    check("R6 write-back address", {32'h0, last_wb_addr}, {32'h0, mk(1, 5, 0)});
    check("R6 R10 written word3", {32'h0, line_of(mk(1, 5, 0))[96 +: 32]}, 64'hCAFE_0001);
    check("R10 written word0", {32'h0, line_of(mk(1, 5, 0))[0 +: 32]}, {32'h0, initval(mk(1, 5, 0))});
    access(0, mk(1, 5, 3), 0, "R6 A refetched keeps store", s);
    check("R6 A refetch evicts clean C", 64'(s), 64'(1 + LAT));

    access(1, mk(5, 9, 0), 32'hBEEF_0005, "R8", s);
    check("R8 store miss stall", 64'(s), 64'(1 + LAT));
    access(0, mk(5, 9, 0), 0, "R8 merged word", s);
    access(0, mk(5, 9, 1), 0, "R8 neighbour word from fill", s);
    access(0, mk(6, 9, 2), 0, "R8 second way fill", s);
    wbs = wb_count;
    access(0, mk(7, 9, 0), 0, "R8 third tag data", s);
    check("R8 dirty allocated line written back", 64'(wb_count), 64'(wbs + 1));
    check("R8 write-back address", {32'h0, last_wb_addr}, {32'h0, mk(5, 9, 0)});
    check("R8 written merged word", {32'h0, line_of(mk(5, 9, 0))[0 +: 32]}, 64'hBEEF_0005);

    // R9: disturb inputs mid-miss
    @(posedge clk); #1;
    cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_addr = mk(8, 20, 2); cpu_wdata = '0;
    exp_q.push_back(ref_word(mk(8, 20, 2))); tag_q.push_back("R9 latched read data");
    repeat (5) @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = mk(9, 30, 1); cpu_wdata = 32'hDEAD_9999;
    repeat (4) @(negedge clk);
    cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_addr = mk(8, 20, 2);
    while (cpu_stall) @(negedge clk);
    check("R9 refill address kept", {32'h0, last_rd_addr}, {32'h0, mk(8, 20, 0)});
    @(posedge clk); #1;
    cpu_rd = 1'b0;
    access(0, mk(9, 30, 1), 0, "R9 ignored store left no data", s);
    check("R9 ignored address misses", 64'(s), 64'(1 + LAT));

    repeat (3) @(posedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule